// File: doc/BRIEF.md
# Frame Accumulation Interval Tracker

This block follows a processing engine frame by frame. The engine raises a start strobe at the beginning of each frame. While the engine reports itself active, each strobe counts as one frame. A 13-bit length input sets how many counted frames make up one accumulation interval. When the frame that completes the interval arrives, the block raises a transfer-busy flag, which tells the host that the result region is being rewritten. On every counted frame it also raises a processing-busy flag.

Both flags hold their value until a halt strobe clears them together. A host interrupt controller takes the two flags and one interrupt pulse per flag. Each pulse is one cycle long and marks only the rising edge of its flag.

Top module: `frame_accum_status`

## Requirements
- R1: A synchronous active-high reset clears the frame counter, both flags and both interrupt pulses.
- R2: A start strobe taken while the engine is active sets the processing-busy flag at the next clock edge. A start strobe taken while the engine is inactive is ignored: it neither sets a flag nor counts a frame.
- R3: The transfer-busy flag rises on the clock edge of the N-th counted frame of an interval, where N is the 13-bit length input (1 to 8191). It does not rise earlier.
- R4: A length value of 0 acts as 1, so every counted frame completes an interval.
- R5: The frame counter returns to zero on the edge that completes an interval, so the next interval again needs N counted frames.
- R6: A halt strobe clears both flags at the next edge. When a halt and a counted frame arrive in the same cycle, both flags end up cleared, but the frame is still counted.
- R7: Each interrupt output goes high for exactly one cycle, in the first cycle its flag is high. A flag that is set again while already high gives no further pulse.
- R8: Both flags stay set until a halt or a reset, whatever happens on the engine inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intervalLen | input | 13 | Frames per accumulation interval (0 acts as 1) |
| frameStart | input | 1 | One-cycle strobe marking the start of a frame |
| engineActive | input | 1 | Engine is processing; frames count only while high |
| haltStb | input | 1 | One-cycle strobe that clears both flags |
| procBusy | output | 1 | Processing-busy flag |
| xferBusy | output | 1 | Transfer-busy flag (interval completed) |
| procIrq | output | 1 | One-cycle pulse on the rising edge of procBusy |
| xferIrq | output | 1 | One-cycle pulse on the rising edge of xferBusy |

## Verification
Several properties are checked on every cycle:
- A halt leaves both flags low.
- Each interrupt pulse lasts a single cycle and falls on a flag edge.
- The counter is zero after an interval closes and holds its value when no frame is counted.
- The transfer flag is never high while the processing flag is low.

Only the bench's scenarios can show that the transfer flag rises on exactly the N-th frame. They cover short lengths, a length of 0 and the 8191 maximum. The bench scenarios also cover frames ignored while the engine is inactive, and the count that survives a halt arriving in the same cycle as a frame.

// File: rtl/frame_accum_pkg.sv
package frame_accum_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic countFrame;    // advance the frame counter
    logic closeInterval; // interval done: reload counter, raise transfer flag
    logic setProc;       // raise processing flag
    logic clearAll;      // drop both flags
  } accStrobes_t;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_PROC = 0;
  localparam int FLAG_XFER = 1;
endpackage

// File: rtl/frame_accum_ctrl.sv
module frame_accum_ctrl
  import frame_accum_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        frameStart,
  input  logic        engineActive,
  input  logic        haltStb,
  input  logic        lastFrame,
  output accStrobes_t strb
);
  logic frameOk;

  assign frameOk = frameStart & engineActive;

  always_comb begin
    strb               = '0;
    strb.countFrame    = frameOk;
    strb.setProc       = frameOk;
    strb.closeInterval = frameOk & lastFrame;
    strb.clearAll      = haltStb;
  end

  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    !engineActive |-> !strb.countFrame && !strb.closeInterval) else $error("idle frame counted"); // R2
endmodule

// File: rtl/frame_accum_dp.sv
module frame_accum_dp
  import frame_accum_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  accStrobes_t      strb,
  input  logic [LEN_W-1:0] intervalLen,
  output logic             lastFrame,
  output logic             procBusy,
  output logic             xferBusy,
  output logic             procIrq,
  output logic             xferIrq
);
  localparam int CW = LEN_W + 1;

  logic [LEN_W-1:0]     frameCnt;
  logic [LEN_W-1:0]     effLen;
  logic [CW-1:0]        nextCnt;
  logic [NUM_FLAGS-1:0] flagSet;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] flagDly;
  logic [NUM_FLAGS-1:0] irq;

  assign effLen    = (intervalLen == '0) ? LEN_W'(1) : intervalLen;
  assign nextCnt   = {1'b0, frameCnt} + CW'(1);
  assign lastFrame = nextCnt >= {1'b0, effLen};

  always_ff @(posedge clk) begin
    if (rst)                     frameCnt <= '0;
    else if (strb.closeInterval) frameCnt <= '0;
    else if (strb.countFrame)    frameCnt <= nextCnt[LEN_W-1:0];
  end

  always_comb begin
    flagSet            = '0;
    flagSet[FLAG_PROC] = strb.setProc;
    flagSet[FLAG_XFER] = strb.closeInterval;
  end

  // One sticky flag and one edge detector per status signal.
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (rst)                flagQ[g] <= 1'b0;
      else if (strb.clearAll) flagQ[g] <= 1'b0;
      else if (flagSet[g])    flagQ[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) flagDly[g] <= 1'b0;
      else     flagDly[g] <= flagQ[g];
    end

    assign irq[g] = flagQ[g] & ~flagDly[g];
  end

  assign procBusy = flagQ[FLAG_PROC];
  assign xferBusy = flagQ[FLAG_XFER];
  assign procIrq  = irq[FLAG_PROC];
  assign xferIrq  = irq[FLAG_XFER];

  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strb.clearAll |=> !procBusy && !xferBusy) else $error("halt did not clear"); // R6
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    strb.closeInterval |=> frameCnt == '0) else $error("counter not reloaded"); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.countFrame |=> $stable(frameCnt)) else $error("counter moved"); // R2
  AST_PROC_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    procIrq |=> !procIrq) else $error("proc irq too long"); // R7
  AST_XFER_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    xferIrq |=> !xferIrq) else $error("xfer irq too long"); // R7
  AST_XFER_IRQ_EDGE: assert property (@(posedge clk) disable iff (rst)
    xferIrq |-> xferBusy) else $error("xfer irq without flag"); // R7
  AST_XFER_WITH_PROC: assert property (@(posedge clk) disable iff (rst)
    xferBusy |-> procBusy) else $error("xfer without proc"); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    procBusy && !strb.clearAll |=> procBusy) else $error("proc flag dropped"); // R8
endmodule

// File: rtl/frame_accum_status.sv
module frame_accum_status
  import frame_accum_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] intervalLen,
  input  logic             frameStart,
  input  logic             engineActive,
  input  logic             haltStb,
  output logic             procBusy,
  output logic             xferBusy,
  output logic             procIrq,
  output logic             xferIrq
);
  accStrobes_t strb;
  logic        lastFrame;

  frame_accum_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .frameStart   (frameStart),
    .engineActive (engineActive),
    .haltStb      (haltStb),
    .lastFrame    (lastFrame),
    .strb         (strb)
  );

  frame_accum_dp #(.LEN_W(LEN_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .intervalLen (intervalLen),
    .lastFrame   (lastFrame),
    .procBusy    (procBusy),
    .xferBusy    (xferBusy),
    .procIrq     (procIrq),
    .xferIrq     (xferIrq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !procBusy && !xferBusy && !procIrq && !xferIrq) else $error("reset state"); // R1
endmodule

// File: tb/sim_frame_accum_status.sv
module sim_frame_accum_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] intervalLen = '0;
  logic        frameStart = 1'b0;
  logic        engineActive = 1'b0;
  logic        haltStb = 1'b0;
  logic        procBusy, xferBusy, procIrq, xferIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  frame_accum_status u0 (
    .clk(clk), .rst(rst), .intervalLen(intervalLen), .frameStart(frameStart),
    .engineActive(engineActive), .haltStb(haltStb), .procBusy(procBusy),
    .xferBusy(xferBusy), .procIrq(procIrq), .xferIrq(xferIrq)
  );

  // Vector table: length, frames applied, expected transfer flag (R3, R4)
  localparam int NV = 8;
  localparam logic [12:0] V_LEN [NV] = '{13'd5, 13'd5, 13'd1, 13'd0, 13'd3, 13'd7, 13'd8191, 13'd8191};
  localparam int          V_FRM [NV] = '{4, 5, 1, 1, 2, 9, 8190, 8191};
  localparam bit          V_XFR [NV] = '{0, 1, 1, 1, 0, 1, 0, 1};

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  // Drive one strobe cycle; returns at the negedge after the capturing posedge.
  task automatic frame(input bit active, input bit halt);
    @(negedge clk);
    frameStart = 1'b1; engineActive = active; haltStb = halt;
    @(negedge clk);
    frameStart = 1'b0; haltStb = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk); haltStb = 1'b1;
    @(negedge clk); haltStb = 1'b0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1 reset state
    doReset();
    chk("R1 procBusy", procBusy, 0);
    chk("R1 xferBusy", xferBusy, 0);
    chk("R1 irqs", {procIrq, xferIrq}, 0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      doReset();
      intervalLen = V_LEN[v];
      for (int f = 0; f < V_FRM[v]; f++) frame(1'b1, 1'b0);
      chk("R3 vector xferBusy", xferBusy, V_XFR[v]);
      chk("R2 vector procBusy", procBusy, 1);
    end

    // R2 inactive frames ignored
    doReset();
    intervalLen = 13'd2;
    frame(1'b0, 1'b0);
    chk("R2 inactive procBusy", procBusy, 0);
    frame(1'b0, 1'b0);
    frame(1'b1, 1'b0);
    chk("R2 inactive not counted xferBusy", xferBusy, 0);

    // R7 pulse timing and R3 rise on N-th frame
    chk("R7 procIrq first cycle", procIrq, 1);
    @(negedge clk);
    chk("R7 procIrq one cycle", procIrq, 0);
    frame(1'b1, 1'b0);
    chk("R3 xferBusy on 2nd frame", xferBusy, 1);
    chk("R7 xferIrq first cycle", xferIrq, 1);
    chk("R7 no proc re-pulse", procIrq, 0);
    @(negedge clk);
    chk("R7 xferIrq one cycle", xferIrq, 0);

    // R8 sticky while engine idles
    engineActive = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 procBusy sticky", procBusy, 1);
    chk("R8 xferBusy sticky", xferBusy, 1);

    // R6 halt clears both
    halt();
    chk("R6 halt procBusy", procBusy, 0);
    chk("R6 halt xferBusy", xferBusy, 0);

    // R5 reload: next interval needs full length again
    intervalLen = 13'd3;
    frame(1'b1, 1'b0); frame(1'b1, 1'b0);
    chk("R5 partial interval", xferBusy, 0);
    frame(1'b1, 1'b0);
    chk("R5 full interval", xferBusy, 1);
    chk("R7 xferIrq after halt", xferIrq, 1);
    halt();
    frame(1'b1, 1'b0); frame(1'b1, 1'b0);
    chk("R5 counter restarted", xferBusy, 0);

    // R6 halt with frame in same cycle: flags clear, frame counted
    doReset();
    intervalLen = 13'd2;
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b1);
    chk("R6 simultaneous procBusy", procBusy, 0);
    chk("R6 simultaneous xferBusy", xferBusy, 0);
    frame(1'b1, 1'b0);
    chk("R6 count survived halt", xferBusy, 0);
    frame(1'b1, 1'b0);
    chk("R6 next interval closes", xferBusy, 1);

    // R4 length zero closes every frame
    doReset();
    intervalLen = 13'd0;
    frame(1'b1, 1'b0);
    chk("R4 zero length", xferBusy, 1);

    // R1 reset clears set flags
    doReset();
    chk("R1 reset after set", {procBusy, xferBusy}, 0);

    finish();
  end
endmodule